// File: doc/BRIEF.md
# Scalar-to-Vector Broadcast Execute Unit

This unit carries out one SIMD operation: it takes a 32-bit scalar from a general-purpose register and copies its low 8, 16 or 32 bits into every lane of one or two 64-bit vector registers. The caller supplies pre-extracted instruction fields and a valid strobe: a two-bit lane-size code, a quad flag, the destination high bit and low nibble, and the source register number. The caller also supplies the scalar itself. The unit keeps a 32-entry, 64-bit vector register file with one write port. A combinational read port exposes that register file.

The unit reports illegal encodings with an undefined flag and a source index of 15 with an unpredictable flag. In both cases it writes no register. Every operation, legal or not and whatever its data, takes exactly two cycles from acceptance to the done pulse. This keeps timing independent of the data.

The control is a three-state machine. IDLE waits for work. When `in_valid` is seen in IDLE, the unit latches the fields and moves to FIRST. In FIRST, the base register is written if the operation is legal, and the machine always moves to SECOND. In SECOND, the odd partner register is written for a legal quad operation, `done` and the flags are presented, and the machine always returns to IDLE.

Top module: `bcast_exec`

## Requirements
- R1: The lane code {sz_b, sz_e} selects the lane width: 2'b00 gives 32-bit lanes (2 per register), 2'b01 gives 16-bit lanes (4), and 2'b10 gives 8-bit lanes (8). Every lane receives the scalar's low lane-width bits unchanged, and the higher scalar bits appear nowhere.
- R2: The destination index is {dst_hi, dst_lo}, with dst_hi as bit 4.
- R3: With quad=0, a legal operation writes only register d. All other registers keep their values.
- R4: With quad=1, a legal operation writes registers d and d+1 with the same pattern, and no others.
- R5: quad=1 with dst_lo[0]=1 raises undef_flag with done and writes no register.
- R6: The lane code 2'b11 raises undef_flag with done and writes no register.
- R7: src_idx equal to 15 raises unpred_flag with done and writes no register. Outside the done cycle, both flags are low.
- R8: done is high for exactly one cycle, the second cycle after the accepting clock edge. This holds for every data value and every fault.
- R9: busy rises in the cycle after acceptance and stays high until done has been shown. An in_valid that arrives while busy is high is ignored.
- R10: A synchronous active-high reset clears all 32 registers to zero and leaves busy and done low.
- R11: rd_data shows register rd_idx combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| sz_b | input | 1 | Lane code, high bit |
| sz_e | input | 1 | Lane code, low bit |
| quad | input | 1 | Write a register pair when set |
| dst_hi | input | 1 | Destination index bit 4 |
| dst_lo | input | 4 | Destination index bits 3:0 |
| src_idx | input | 4 | Source general-purpose register number |
| scalar | input | 32 | Value read from the source register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | Undefined encoding, valid with done |
| unpred_flag | output | 1 | Unpredictable source, valid with done |
| rd_idx | input | 5 | Read port index |
| rd_data | output | 64 | Read port data |

## Verification
The bench sweeps every lane code with both quad settings, two destination halves, odd and even low nibbles and two source indexes, using scalars whose upper bits differ from their lower bits. After each operation it compares all 32 registers against a model. Each fault case targets a specific mistake:
- A lane decoder with swapped codes, or one that leaks scalar upper bits, shows up as a wrong lane pattern.
- A design that forgets to suppress writes on a fault, or that writes d+1 for a double operation, corrupts a register the model says is untouched.
- A missing odd-base check appears as an absent undef_flag.
- On some operations the bench holds a second, differently targeted request while the unit is busy. A machine that accepts it overwrites another register.
- Any data-dependent or fault-dependent shortcut shifts the done pulse out of the sampled cycle.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
    localparam int VEC_W   = 64;
    localparam int NUM_REG = 32;
    localparam int REG_AW  = $clog2(NUM_REG);
    localparam int SCL_W   = 32;
    localparam int SRC_W   = 4;
    localparam logic [SRC_W-1:0] SRC_PC = 4'd15;

    typedef enum logic [1:0] {
        LANE_32   = 2'b00,
        LANE_16   = 2'b01,
        LANE_8    = 2'b10,
        LANE_RSVD = 2'b11
    } lane_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FIRST  = 2'b01,
        ST_SECOND = 2'b10
    } state_e;
endpackage

// File: rtl/bcast_decode.sv
module bcast_decode
    import bcast_pkg::*;
(
    input  logic              sz_b,
    input  logic              sz_e,
    input  logic              quad,
    input  logic              dst_hi,
    input  logic [3:0]        dst_lo,
    input  logic [SRC_W-1:0]  src_idx,
    output lane_e             lane,
    output logic [REG_AW-1:0] base,
    output logic              undef,
    output logic              unpred
);
    always_comb begin
        lane   = lane_e'({sz_b, sz_e});
        base   = {dst_hi, dst_lo};
        undef  = (lane == LANE_RSVD) || (quad && dst_lo[0]);
        unpred = (src_idx == SRC_PC);
    end
endmodule

// File: rtl/bcast_replicate.sv
module bcast_replicate
    import bcast_pkg::*;
#(
    parameter int DW = VEC_W,
    parameter int SW = SCL_W
) (
    input  lane_e          lane,
    input  logic [SW-1:0]  src,
    output logic [DW-1:0]  pattern
);
    localparam int N8  = DW / 8;
    localparam int N16 = DW / 16;
    localparam int N32 = DW / 32;

    logic [DW-1:0] rep8, rep16, rep32;

    for (genvar i = 0; i < N8; i++) begin : g_l8
        assign rep8[i*8 +: 8] = src[7:0];
    end
    for (genvar i = 0; i < N16; i++) begin : g_l16
        assign rep16[i*16 +: 16] = src[15:0];
    end
    for (genvar i = 0; i < N32; i++) begin : g_l32
        assign rep32[i*32 +: 32] = src[31:0];
    end

    always_comb begin
        unique case (lane)
            LANE_32: pattern = rep32;
            LANE_16: pattern = rep16;
            LANE_8:  pattern = rep8;
            default: pattern = '0;
        endcase
    end
endmodule

// File: rtl/bcast_regfile.sv
module bcast_regfile
    import bcast_pkg::*;
#(
    parameter int DW = VEC_W,
    parameter int NR = NUM_REG,
    localparam int AW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] mem [NR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];
endmodule

// File: rtl/bcast_exec.sv
module bcast_exec
    import bcast_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              sz_b,
    input  logic              sz_e,
    input  logic              quad,
    input  logic              dst_hi,
    input  logic [3:0]        dst_lo,
    input  logic [SRC_W-1:0]  src_idx,
    input  logic [SCL_W-1:0]  scalar,
    output logic              busy,
    output logic              done,
    output logic              undef_flag,
    output logic              unpred_flag,
    input  logic [REG_AW-1:0] rd_idx,
    output logic [VEC_W-1:0]  rd_data
);
    state_e state, state_nx;

    lane_e             dec_lane;
    logic [REG_AW-1:0] dec_base;
    logic              dec_undef, dec_unpred;

    lane_e             op_lane;
    logic [REG_AW-1:0] op_base;
    logic              op_quad, op_undef, op_unpred;
    logic [SCL_W-1:0]  op_scalar;

    logic [VEC_W-1:0]  pattern;
    logic              wr_en;
    logic [REG_AW-1:0] wr_addr;
    logic              accept;

    bcast_decode u_dec (
        .sz_b    (sz_b),
        .sz_e    (sz_e),
        .quad    (quad),
        .dst_hi  (dst_hi),
        .dst_lo  (dst_lo),
        .src_idx (src_idx),
        .lane    (dec_lane),
        .base    (dec_base),
        .undef   (dec_undef),
        .unpred  (dec_unpred)
    );

    assign accept = in_valid && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_lane   <= LANE_32;
            op_base   <= '0;
            op_quad   <= 1'b0;
            op_undef  <= 1'b0;
            op_unpred <= 1'b0;
            op_scalar <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_lane   <= dec_lane;
                op_base   <= dec_base;
                op_quad   <= quad;
                op_undef  <= dec_undef;
                op_unpred <= dec_unpred;
                op_scalar <= scalar;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (in_valid) state_nx = ST_FIRST;
            ST_FIRST:  state_nx = ST_SECOND;
            ST_SECOND: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        undef_flag  = 1'b0;
        unpred_flag = 1'b0;
        wr_en       = 1'b0;
        wr_addr     = op_base;
        unique case (state)
            ST_IDLE: ;
            ST_FIRST: begin
                busy  = 1'b1;
                wr_en = !op_undef && !op_unpred;
            end
            ST_SECOND: begin
                busy        = 1'b1;
                done        = 1'b1;
                undef_flag  = op_undef;
                unpred_flag = op_unpred;
                wr_en       = op_quad && !op_undef && !op_unpred;
                wr_addr     = op_base + REG_AW'(1);
            end
            default: ;
        endcase
    end

    bcast_replicate u_rep (
        .lane    (op_lane),
        .src     (op_scalar),
        .pattern (pattern)
    );

    bcast_regfile u_rf (
        .clk (clk),
        .rst (rst),
        .we  (wr_en),
        .wa  (wr_addr),
        .wd  (pattern),
        .ra  (rd_idx),
        .rd  (rd_data)
    );
endmodule

// File: rtl/bcast_exec_chk.sv
module bcast_exec_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic busy,
    input logic done,
    input logic undef_flag,
    input logic unpred_flag,
    input logic wr_en
);
    assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |=> (busy && !done));

    assert_two_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> done);

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_idle_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !in_valid) |=> !busy);

    assert_flags_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        (undef_flag || unpred_flag) |-> done);

    assert_undef_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        (done && undef_flag) |-> (!wr_en && !$past(wr_en)));

    assert_unpred_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (done && unpred_flag) |-> (!wr_en && !$past(wr_en)));

    assert_write_when_busy_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);
endmodule

bind bcast_exec bcast_exec_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .busy        (busy),
    .done        (done),
    .undef_flag  (undef_flag),
    .unpred_flag (unpred_flag),
    .wr_en       (wr_en)
);

// File: tb/bcast_exec_test.sv
module bcast_exec_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        sz_b, sz_e, quad, dst_hi;
    logic [3:0]  dst_lo, src_idx;
    logic [31:0] scalar;
    logic        busy, done, undef_flag, unpred_flag;
    logic [4:0]  rd_idx;
    logic [63:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [63:0] model [32];

    always #5 clk = ~clk;

    bcast_exec uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .sz_b(sz_b), .sz_e(sz_e), .quad(quad), .dst_hi(dst_hi),
        .dst_lo(dst_lo), .src_idx(src_idx), .scalar(scalar),
        .busy(busy), .done(done), .undef_flag(undef_flag),
        .unpred_flag(unpred_flag), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_pattern(input logic [1:0] code, input logic [31:0] s);
        int esz;
        logic [63:0] v = '0;
        logic [63:0] m;
        esz = (code == 2'b00) ? 32 : (code == 2'b01) ? 16 : 8;
        m = (64'd1 << esz) - 64'd1;
        for (int i = 0; i < 64 / esz; i++) v = v | ((64'(s) & m) << (i * esz));
        return v;
    endfunction

    task automatic sweep_regs(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_idx = 5'(i);
            #1;
            check(rd_data === model[i], req, rd_data, model[i]);
        end
    endtask

    task automatic run_op(input logic [1:0] code, input logic q, input logic dh,
                          input logic [3:0] v, input logic [3:0] r,
                          input logic [31:0] s, input bit spam);
        logic e_undef, e_unpred;
        logic [4:0] d;
        logic [63:0] pat;
        e_undef  = (code == 2'b11) || (q && v[0]);
        e_unpred = (r == 4'd15);
        d = {dh, v};
        @(negedge clk);
        {sz_b, sz_e} = code; quad = q; dst_hi = dh; dst_lo = v;
        src_idx = r; scalar = s; in_valid = 1'b1;
        @(negedge clk);
        check(busy === 1'b1 && done === 1'b0, "R9 busy after accept", {62'd0, busy, done}, 64'd2);
        if (spam) begin
            {sz_b, sz_e} = 2'b10; quad = 1'b0; dst_hi = ~dh; dst_lo = ~v;
            src_idx = 4'd1; scalar = ~s;
        end else begin
            in_valid = 1'b0;
        end
        @(negedge clk);
        check(done === 1'b1, "R8 done in second cycle", {63'd0, done}, 64'd1);
        check(undef_flag === e_undef, "R5 R6 undef flag", {63'd0, undef_flag}, {63'd0, e_undef});
        check(unpred_flag === e_unpred, "R7 unpred flag", {63'd0, unpred_flag}, {63'd0, e_unpred});
        @(negedge clk);
        in_valid = 1'b0;
        check(busy === 1'b0 && done === 1'b0 && undef_flag === 1'b0 && unpred_flag === 1'b0,
              "R8 R9 idle after done", {60'd0, busy, done, undef_flag, unpred_flag}, 64'd0);
        if (!e_undef && !e_unpred) begin
            pat = expect_pattern(code, s);
            model[d] = pat;
            if (q) model[d + 5'd1] = pat;
        end
        sweep_regs(q ? "R1 R2 R4 R9 register contents" : "R1 R2 R3 R9 register contents");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [3];
        logic [3:0]  vds  [4];
        pats[0] = 32'hA5C3_7E19; pats[1] = 32'h1234_56F0; pats[2] = 32'hFFFF_0081;
        vds[0] = 4'd0; vds[1] = 4'd5; vds[2] = 4'd10; vds[3] = 4'd15;
        rst = 1'b1; in_valid = 1'b0; sz_b = 1'b0; sz_e = 1'b0; quad = 1'b0;
        dst_hi = 1'b0; dst_lo = 4'd0; src_idx = 4'd0; scalar = '0; rd_idx = '0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R10 reset outputs", {62'd0, busy, done}, 64'd0);
        rst = 1'b0;
        sweep_regs("R10 R11 registers cleared");
        for (int c = 0; c < 4; c++)
            for (int q = 0; q < 2; q++)
                for (int h = 0; h < 2; h++)
                    for (int vi = 0; vi < 4; vi++)
                        for (int ri = 0; ri < 2; ri++)
                            for (int k = 0; k < 3; k++)
                                run_op(2'(c), q[0], h[0], vds[vi], ri ? 4'd15 : 4'd3,
                                       pats[k] ^ {8'(c * 16 + vi), 24'd0}, k == 1);
        run_op(2'b01, 1'b1, 1'b1, 4'd14, 4'd0, 32'hDEAD_BEEF, 1'b1);
        check(model[31] === 64'hBEEF_BEEF_BEEF_BEEF, "R4 top pair model", model[31], 64'hBEEF_BEEF_BEEF_BEEF);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule